// File: doc/BRIEF.md
# Two-Channel DMA Request Arbiter

This block decides which of two DMA channels may use the bus, and when the CPU may take an interrupt. Each channel has a transfer request input, a direction bit, a RAM address counter and a transfer counter. Software or a neighbouring block preloads the counters through a load port. A request on a channel with a non-zero count is latched and waits until the bus is free. The block then grants one channel and raises a bus request. The transfer is finished in the cycle the bus acknowledges it. At that point the channel's RAM address steps up by one and its count steps down by one.

A running transfer is never cut short. Channel 0 beats channel 1 when both are waiting. A hold-off input from the CPU marks the cycle that follows a call, a software break or an interrupt-flag bit operation; in that cycle no new grant is issued. An interrupt request waits until no DMA transfer is running or being granted. Every transfer address is checked against a permitted RAM window and against the general-purpose register area. A transfer to a forbidden address sets a sticky error flag. Its RAM write is suppressed, and data going to the peripheral side is forced to zero.

Top module: `dma_arb2`

## Requirements
- R1: Once `bus_req` is high, it stays high and `bus_ch` stays unchanged until the cycle in which `bus_ack` is high. A request on the other channel during that time is held pending and is served after the running transfer ends.
- R2: When both channels are eligible in the same arbitration cycle, channel 0 (`bus_ch` = 0) is granted first and channel 1 afterwards.
- R3: `irq_ack` is a one-cycle pulse. It is never high together with `bus_req`, and it is never high in a cycle where a DMA grant is being made. An interrupt request raised together with a DMA request is acknowledged only after that DMA transfer completes. An interrupt request on an idle block gives `irq_ack` in the next cycle.
- R4: In a cycle where `holdoff` is high, no new grant is made. A request seen in that cycle stays pending and is granted once `holdoff` is low.
- R5: Each completed transfer increments the channel's RAM address by exactly one. The next transfer on that channel presents the incremented address on `bus_addr`.
- R6: The permitted window is RAM_LO..RAM_HI, excluding GPR_LO..GPR_HI. A transfer whose address lies outside it sets the sticky `err` flag in the cycle after its acknowledge. For such a transfer `bus_ram_we` is 0 in SFR-to-RAM mode (`ch_dir` bit = 0), and `sfr_wdata` is all zero in RAM-to-SFR mode (`ch_dir` bit = 1). An in-window transfer leaves `err` unchanged. In-window transfers drive `bus_ram_we` = 1 in SFR-to-RAM mode and pass `ram_rdata` to `sfr_wdata` in RAM-to-SFR mode.
- R7: Each accepted request makes exactly one transfer and decrements the channel's count. When the count reaches zero, the matching `done` bit pulses for one cycle. A request on a channel whose count is zero is ignored.
- R8: Pending state is a single bit per channel. Several request pulses on a channel that is already pending produce only one transfer.
- R9: A request seen at a clock edge drives `bus_req` high after that edge. After the acknowledge cycle, `bus_req` is low for at least one cycle before the next grant.
- R10: Synchronous active-high `rst` clears the pending bits, the active transfer, the interrupt state and `err`. While `rst` is high, `bus_req`, `irq_ack`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_req | input | NCH | Transfer request pulse per channel |
| ch_dir | input | NCH | Per-channel direction: 0 = SFR to RAM, 1 = RAM to SFR |
| ld_en | input | 1 | Load address and count into channel `ld_ch` |
| ld_ch | input | CHW | Channel selected for loading |
| ld_addr | input | AW | RAM start address to load |
| ld_cnt | input | CW | Transfer count to load |
| holdoff | input | 1 | CPU marks a cycle in which no grant may be issued |
| irq_req | input | 1 | Interrupt request from the interrupt path |
| irq_ack | output | 1 | Interrupt may be serviced (one-cycle pulse) |
| bus_req | output | 1 | DMA transfer in progress |
| bus_ack | input | 1 | Bus completes the current transfer |
| bus_ch | output | CHW | Channel owning the current transfer |
| bus_addr | output | AW | RAM address of the current transfer |
| bus_dir | output | 1 | Direction of the current transfer |
| bus_ram_we | output | 1 | RAM write enable for the current transfer |
| ram_rdata | input | DW | Data read from RAM |
| sfr_wdata | output | DW | Data toward the peripheral register |
| done | output | NCH | One-cycle pulse when a channel's count reaches zero |
| err | output | 1 | Sticky forbidden-address flag |

## Verification
The bench raises both channel requests in one cycle and expects channel 0 first; a design with reversed or missing priority shows channel 1 first in the scoreboard. It sends a request on the other channel during a slow transfer, and sends repeated pulses to an already pending channel; a design that preempts changes `bus_ch` mid-transfer, and one that counts pulses issues an extra transfer. It raises hold-off together with a request and expects no grant that cycle. It raises an interrupt together with a DMA request and expects the acknowledge only once the scoreboard is empty. It steps an address from the last allowed byte into the register area, and a design with an off-by-one bound either writes RAM there or never flags `err`.

// File: rtl/dma_arb2_pkg.sv
package dma_arb2_pkg;
  typedef enum logic {
    DIR_SFR2RAM = 1'b0,
    DIR_RAM2SFR = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/dma_chan.sv
// Per-channel RAM address counter and transfer counter.
module dma_chan #(
  parameter int AW = 10,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [AW-1:0] ld_addr,
  input  logic [CW-1:0] ld_cnt,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic          cnt_nz,
  output logic          last,
  output logic          done
);
  logic [CW-1:0] cnt;

  assign cnt_nz = (cnt != '0);
  assign last   = (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= step && last;
      if (ld) begin
        addr <= ld_addr;
        cnt  <= ld_cnt;
      end else if (step) begin
        addr <= addr + AW'(1);
        cnt  <= cnt - CW'(1);
      end
    end
  end
endmodule

// File: rtl/dma_prio.sv
// Fixed-priority pick: lowest channel index wins.
module dma_prio #(
  parameter int NCH = 2,
  parameter int CHW = 1
) (
  input  logic           can,
  input  logic [NCH-1:0] elig,
  output logic [NCH-1:0] gnt,
  output logic [CHW-1:0] idx,
  output logic           any
);
  always_comb begin
    gnt = '0;
    idx = '0;
    any = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (can && elig[i] && !any) begin
        gnt[i] = 1'b1;
        idx    = CHW'(i);
        any    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_arb2.sv
module dma_arb2
  import dma_arb2_pkg::*;
#(
  parameter int NCH = 2,
  parameter int AW  = 10,
  parameter int CW  = 8,
  parameter int DW  = 8,
  parameter logic [AW-1:0] RAM_LO = 10'h100,
  parameter logic [AW-1:0] RAM_HI = 10'h3BF,
  parameter logic [AW-1:0] GPR_LO = 10'h3A0,
  parameter logic [AW-1:0] GPR_HI = 10'h3BF,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] ch_req,
  input  logic [NCH-1:0] ch_dir,
  input  logic           ld_en,
  input  logic [CHW-1:0] ld_ch,
  input  logic [AW-1:0]  ld_addr,
  input  logic [CW-1:0]  ld_cnt,
  input  logic           holdoff,
  input  logic           irq_req,
  output logic           irq_ack,
  output logic           bus_req,
  input  logic           bus_ack,
  output logic [CHW-1:0] bus_ch,
  output logic [AW-1:0]  bus_addr,
  output logic           bus_dir,
  output logic           bus_ram_we,
  input  logic [DW-1:0]  ram_rdata,
  output logic [DW-1:0]  sfr_wdata,
  output logic [NCH-1:0] done,
  output logic           err
);
  logic [AW-1:0]  ch_addr [NCH];
  logic [NCH-1:0] nz, last, step, bad_of, pend, elig, gnt;
  logic [CHW-1:0] gnt_idx;
  logic           gnt_any, can, bad_r, irq_pend, irq_fire;

  // Channel datapaths and address range check, one per channel.
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign step[c] = bus_req && bus_ack && (bus_ch == CHW'(c));

    dma_chan #(.AW(AW), .CW(CW)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .ld      (ld_en && (ld_ch == CHW'(c))),
      .ld_addr (ld_addr),
      .ld_cnt  (ld_cnt),
      .step    (step[c]),
      .addr    (ch_addr[c]),
      .cnt_nz  (nz[c]),
      .last    (last[c]),
      .done    (done[c])
    );

    assign bad_of[c] = (ch_addr[c] < RAM_LO) || (ch_addr[c] > RAM_HI) ||
                       ((ch_addr[c] >= GPR_LO) && (ch_addr[c] <= GPR_HI));
  end

  // Arbitration happens only with the bus idle and no hold-off.
  assign elig = pend | (ch_req & nz);
  assign can  = !bus_req && !holdoff;

  dma_prio #(.NCH(NCH), .CHW(CHW)) u_prio (
    .can  (can),
    .elig (elig),
    .gnt  (gnt),
    .idx  (gnt_idx),
    .any  (gnt_any)
  );

  assign irq_fire = (irq_pend || irq_req) && !bus_req && !gnt_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend       <= '0;
      bus_req    <= 1'b0;
      bus_ch     <= '0;
      bus_addr   <= '0;
      bus_dir    <= 1'b0;
      bus_ram_we <= 1'b0;
      bad_r      <= 1'b0;
      err        <= 1'b0;
      irq_pend   <= 1'b0;
      irq_ack    <= 1'b0;
    end else begin
      // Single-bit pending latch; a channel finishing its last transfer drops its pend.
      pend <= (pend | (ch_req & nz)) & ~gnt & ~(step & last);

      if (gnt_any) begin
        bus_req    <= 1'b1;
        bus_ch     <= gnt_idx;
        bus_addr   <= ch_addr[gnt_idx];
        bus_dir    <= ch_dir[gnt_idx];
        bad_r      <= bad_of[gnt_idx];
        bus_ram_we <= (xfer_dir_e'(ch_dir[gnt_idx]) == DIR_SFR2RAM) && !bad_of[gnt_idx];
      end else if (bus_req && bus_ack) begin
        bus_req    <= 1'b0;
        bus_ram_we <= 1'b0;
      end

      err      <= err || (bus_req && bus_ack && bad_r);
      irq_pend <= (irq_pend || irq_req) && !irq_fire;
      irq_ack  <= irq_fire;
    end
  end

  assign sfr_wdata = (bus_req && (xfer_dir_e'(bus_dir) == DIR_RAM2SFR) && !bad_r)
                     ? ram_rdata : '0;
endmodule

// File: rtl/dma_arb2_chk.sv
module dma_arb2_chk #(
  parameter int NCH = 2,
  parameter int CHW = 1
) (
  input logic           clk,
  input logic           rst,
  input logic [NCH-1:0] ch_req,
  input logic [NCH-1:0] nz,
  input logic           holdoff,
  input logic           bus_req,
  input logic           bus_ack,
  input logic [CHW-1:0] bus_ch,
  input logic           irq_ack,
  input logic [NCH-1:0] done,
  input logic           err
);
  // R1
  hold_active_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> bus_req && $stable(bus_ch));

  // R2
  ch0_first_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_req && !holdoff && ch_req[0] && nz[0] |=> bus_req && (bus_ch == '0));

  // R3
  irq_apart_chk: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> !bus_req);

  // R4
  holdoff_block_chk: assert property (@(posedge clk) disable iff (rst)
    holdoff && !bus_req |=> !bus_req);

  // R9
  idle_gap_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_ack |=> !bus_req);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(done));

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
endmodule

bind dma_arb2 dma_arb2_chk #(.NCH(NCH), .CHW(CHW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ch_req  (ch_req),
  .nz      (nz),
  .holdoff (holdoff),
  .bus_req (bus_req),
  .bus_ack (bus_ack),
  .bus_ch  (bus_ch),
  .irq_ack (irq_ack),
  .done    (done),
  .err     (err)
);

// File: tb/dma_arb2_tb.sv
module dma_arb2_tb;
  localparam int NCH = 2, AW = 10, CW = 8, DW = 8, CHW = 1;

  logic clk = 1'b0, rst = 1'b1;
  logic [NCH-1:0] ch_req = '0, ch_dir = '0, done;
  logic ld_en = 1'b0;
  logic [CHW-1:0] ld_ch = '0, bus_ch;
  logic [AW-1:0] ld_addr = '0, bus_addr;
  logic [CW-1:0] ld_cnt = '0;
  logic holdoff = 1'b0, irq_req = 1'b0, irq_ack, bus_req, bus_ack = 1'b0;
  logic bus_dir, bus_ram_we, err;
  logic [DW-1:0] ram_rdata = 8'hA5, sfr_wdata;

  always #10 clk = ~clk;

  dma_arb2 u_dut (
    .clk(clk), .rst(rst), .ch_req(ch_req), .ch_dir(ch_dir),
    .ld_en(ld_en), .ld_ch(ld_ch), .ld_addr(ld_addr), .ld_cnt(ld_cnt),
    .holdoff(holdoff), .irq_req(irq_req), .irq_ack(irq_ack),
    .bus_req(bus_req), .bus_ack(bus_ack), .bus_ch(bus_ch), .bus_addr(bus_addr),
    .bus_dir(bus_dir), .bus_ram_we(bus_ram_we), .ram_rdata(ram_rdata),
    .sfr_wdata(sfr_wdata), .done(done), .err(err)
  );

  typedef struct {
    logic [CHW-1:0] ch;
    logic [AW-1:0]  addr;
    logic           we;
    logic [DW-1:0]  data;
  } xfer_t;

  xfer_t sb_q[$];
  int checks = 0, errors = 0;
  int lat = 2, lat_cnt = 0;
  int grant_n = 0, irq_n = 0, done0_n = 0, done1_n = 0;
  logic bus_req_d = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic expect_xfer(input int ch, input int addr, input bit we, input int data);
    xfer_t t;
    t.ch = CHW'(ch); t.addr = AW'(addr); t.we = we; t.data = DW'(data);
    sb_q.push_back(t);
  endtask

  // Bus responder and scoreboard monitor.
  always @(negedge clk) begin
    if (rst) begin
      bus_ack = 1'b0; lat_cnt = 0; bus_req_d = 1'b0;
    end else begin
      if (bus_req && !bus_req_d) grant_n++;
      bus_req_d = bus_req;
      if (done[0]) done0_n++;
      if (done[1]) done1_n++;
      if (irq_ack) begin
        irq_n++;
        check(!bus_req && sb_q.size() == 0, "R3", "irq_ack before DMA finished",
              sb_q.size(), 0);
      end
      if (bus_ack) begin
        bus_ack = 1'b0; lat_cnt = 0;
      end else if (bus_req) begin
        lat_cnt++;
        if (lat_cnt >= lat) begin
          bus_ack = 1'b1;
          if (sb_q.size() == 0) begin
            check(1'b0, "R7", "unexpected transfer addr", int'(bus_addr), 0);
          end else begin
            xfer_t e;
            e = sb_q.pop_front();
            check(bus_ch == e.ch, "R2", "bus_ch", int'(bus_ch), int'(e.ch));
            check(bus_addr == e.addr, "R5", "bus_addr", int'(bus_addr), int'(e.addr));
            check(bus_ram_we == e.we, "R6", "bus_ram_we", int'(bus_ram_we), int'(e.we));
            check(sfr_wdata == e.data, "R6", "sfr_wdata", int'(sfr_wdata), int'(e.data));
          end
        end
      end
    end
  end

  task automatic load(input int ch, input int addr, input int cnt, input bit dir);
    @(negedge clk);
    ld_en = 1'b1; ld_ch = CHW'(ch); ld_addr = AW'(addr); ld_cnt = CW'(cnt);
    ch_dir[ch] = dir;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic pulse(input logic [NCH-1:0] m);
    @(negedge clk); ch_req = m;
    @(negedge clk); ch_req = '0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (sb_q.size() == 0 && !bus_req) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R9", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int g0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(!bus_req && !irq_ack && !err && done == '0, "R10", "outputs in reset",
          {bus_req, irq_ack, err}, 0);
    rst = 1'b0;

    load(0, 'h100, 3, 1'b0);
    load(1, 'h200, 2, 1'b1);

    // R2: simultaneous requests; R9 grant timing
    expect_xfer(0, 'h100, 1'b1, 0);
    expect_xfer(1, 'h200, 1'b0, 'hA5);
    @(negedge clk); ch_req = 2'b11;
    @(negedge clk); ch_req = '0;
    check(bus_req && bus_ch == 0, "R9", "bus_req/ch after request", {bus_req, bus_ch}, 2'b10);
    wait_idle();

    // R1: other channel arrives during a transfer
    expect_xfer(0, 'h101, 1'b1, 0);
    expect_xfer(1, 'h201, 1'b0, 'hA5);
    @(negedge clk); ch_req = 2'b01;
    @(negedge clk); ch_req = 2'b10;
    check(bus_req && bus_ch == 0, "R1", "channel 0 running", bus_ch, 0);
    @(negedge clk); ch_req = '0;
    check(bus_req && bus_ch == 0, "R1", "no preemption", bus_ch, 0);
    wait_idle();
    check(done1_n == 1 && done0_n == 0, "R7", "done pulses ch1/ch0", {done1_n[3:0], done0_n[3:0]}, 8'h10);

    // R7: request on exhausted channel ignored
    g0 = grant_n;
    pulse(2'b10);
    repeat (5) @(negedge clk);
    check(grant_n == g0 && !bus_req, "R7", "grants after zero-count request", grant_n - g0, 0);

    // R4: hold-off cycle
    expect_xfer(0, 'h102, 1'b1, 0);
    @(negedge clk); ch_req = 2'b01; holdoff = 1'b1;
    @(negedge clk); ch_req = '0; holdoff = 1'b0;
    check(!bus_req, "R4", "grant during holdoff", bus_req, 0);
    @(negedge clk);
    check(bus_req && bus_ch == 0, "R4", "pending served after holdoff", bus_req, 1);
    wait_idle();
    check(done0_n == 1, "R7", "done pulse ch0", done0_n, 1);

    // R8: repeated pulses on a pending channel
    load(0, 'h110, 5, 1'b0);
    load(1, 'h300, 4, 1'b1);
    lat = 5;
    g0 = grant_n;
    expect_xfer(1, 'h300, 1'b0, 'hA5);
    expect_xfer(0, 'h110, 1'b1, 0);
    @(negedge clk); ch_req = 2'b10;
    @(negedge clk); ch_req = 2'b01;
    @(negedge clk); ch_req = '0;
    @(negedge clk); ch_req = 2'b01;
    @(negedge clk); ch_req = '0;
    wait_idle();
    lat = 2;
    check(grant_n - g0 == 2, "R8", "transfers from repeated pulses", grant_n - g0, 2);

    // R3: interrupt together with DMA, then alone
    expect_xfer(0, 'h111, 1'b1, 0);
    @(negedge clk); ch_req = 2'b01; irq_req = 1'b1;
    @(negedge clk); ch_req = '0; irq_req = 1'b0;
    check(bus_req && !irq_ack, "R3", "DMA wins over interrupt", {bus_req, irq_ack}, 2'b10);
    wait_idle();
    check(irq_n == 1, "R3", "interrupt acknowledged after DMA", irq_n, 1);
    @(negedge clk); irq_req = 1'b1;
    @(negedge clk); irq_req = 1'b0;
    check(irq_ack, "R3", "irq_ack on idle block", irq_ack, 1);
    @(negedge clk);
    check(!irq_ack && irq_n == 2, "R3", "irq_ack single pulse", irq_ack, 0);

    // R6 / R5: last allowed byte then register area
    load(0, 'h39F, 2, 1'b0);
    expect_xfer(0, 'h39F, 1'b1, 0);
    pulse(2'b01);
    wait_idle();
    check(!err, "R6", "err after in-window transfer", err, 0);
    expect_xfer(0, 'h3A0, 1'b0, 0);
    pulse(2'b01);
    wait_idle();
    check(err, "R6", "err after register-area transfer", err, 1);
    load(1, 'h0FF, 1, 1'b1);
    expect_xfer(1, 'h0FF, 1'b0, 0);
    pulse(2'b10);
    wait_idle();
    check(err, "R6", "err sticky", err, 1);

    // R10: reset clears err
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check(!err && !bus_req && !irq_ack, "R10", "reset clears err", err, 0);
    rst = 1'b0;
    @(negedge clk);
    check(sb_q.size() == 0, "R9", "scoreboard drained", sb_q.size(), 0);
    finish_run();
  end
endmodule